// File: doc/BRIEF.md
# Variable Pulse Width Symbol Decoder

This block sits behind the receive pin of a single-wire variable pulse width bus. The bus is passive when low and active when high. The block synchronizes the level, removes short glitches, and times every phase between two edges with a tick-driven counter. Each time a phase ends, the block compares its length with a ladder of run-time thresholds and reports one symbol: invalid, logic zero, logic one, end-of-data, end-of-frame, end-of-frame with inter-frame separation, start-of-frame or idle bus.

The same timing drives two transmit signals for a local node that has a frame queued. The node may start on its own once the bus has been passive for the full separation time. After an end-of-frame has been seen, the node is also told to start at once on the next rising edge, so it joins arbitration with nodes whose separation timers ran a little faster.

Thresholds are given in ticks, and the tick is an input enable. The bus level itself is a plain asynchronous input.

Top module: `vpw_sym_decoder`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `sym_valid_o`, `tx_start_o` and `tx_grant_o` are low.
- R2: A passive phase of L ticks ends at a rising edge and is reported with `sym_active_o`=0. The symbol code depends on L: L<B gives 0 (invalid), B<=L<C gives 1 (zero), C<=L<D gives 2 (one), D<=L<E gives 3 (end-of-data), E<=L<F gives 4 (end-of-frame), F<=L<G gives 5 (end-of-frame plus separation), and L>=G gives 6 (idle). A passive phase never reports code 7.
- R3: An active phase of L ticks ends at a falling edge and is reported with `sym_active_o`=1. L<B gives 0 (invalid), B<=L<C gives 2 (one), C<=L<D gives 1 (zero), and L>=D gives 7 (start-of-frame).
- R4: A bus pulse of one or two clocks that does not match the current filtered level is ignored. It neither ends the phase nor changes the measured length.
- R5: When the bus stays passive for G ticks, code 6 is reported exactly once, whether or not a rising edge follows. The counter saturates at G+1, so the code is not repeated.
- R6: `tx_grant_o` is high only while `tx_pending_i` is high, the bus is passive and idle has been declared for the current passive phase.
- R7: `tx_start_o` pulses for one cycle on a rising edge that ends a passive phase of at least E ticks while `tx_pending_i` is high. It does not pulse after shorter phases.
- R8: The phase counter advances only in cycles where `tick_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time-base enable for the phase counter |
| bus_i | input | 1 | Raw bus level, 1 = active |
| thr_b_i | input | CNT_W | Shortest valid bit, in ticks |
| thr_c_i | input | CNT_W | Short/long bit boundary |
| thr_d_i | input | CNT_W | Longest bit / end-of-data and start-of-frame start |
| thr_e_i | input | CNT_W | End-of-frame start |
| thr_f_i | input | CNT_W | Separation start |
| thr_g_i | input | CNT_W | Idle threshold |
| tx_pending_i | input | 1 | Local node has a frame queued |
| sym_valid_o | output | 1 | One-cycle strobe for a new symbol |
| sym_o | output | 3 | Symbol code (see R2, R3) |
| sym_active_o | output | 1 | 1 when the measured phase was active |
| tx_start_o | output | 1 | Start now, on a rising edge after end-of-frame |
| tx_grant_o | output | 1 | Own-initiative start allowed |

## Verification
The assertions assume that the thresholds are strictly ordered and that G stays below the counter's top value. They also assume that the thresholds do not change while a phase is being timed. The stimulus keeps the default thresholds for the whole run and holds every intended bus phase for at least 33 clocks. The only shorter pulses are deliberate glitches of two clocks, which test the filter. Phase lengths are placed on both sides of every threshold. The tick runs either every cycle or every second cycle.

// File: rtl/vpw_pkg.sv
package vpw_pkg;
  typedef enum logic [2:0] {
    SYM_INVALID = 3'd0,
    SYM_ZERO    = 3'd1,
    SYM_ONE     = 3'd2,
    SYM_EOD     = 3'd3,
    SYM_EOF     = 3'd4,
    SYM_EOF_IFS = 3'd5,
    SYM_IDLE    = 3'd6,
    SYM_SOF     = 3'd7
  } vpw_sym_e;
endpackage

// File: rtl/vpw_bus_filter.sv
module vpw_bus_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist_q;
  logic level_q, rise_q, fall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '0;
      hist_q  <= '0;
      level_q <= 1'b0;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], bus_i};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      // level flips only when the whole window agrees
      if (&hist_q && !level_q) begin
        level_q <= 1'b1;
        rise_q  <= 1'b1;
      end else if (~|hist_q && level_q) begin
        level_q <= 1'b0;
        fall_q  <= 1'b1;
      end
    end
  end

  assign level_o = level_q;
  assign rise_o  = rise_q;
  assign fall_o  = fall_q;
endmodule

// File: rtl/vpw_phase_timer.sv
module vpw_phase_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] sat_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      // the edge cycle already belongs to the new phase
      cnt_q <= {{(CNT_W-1){1'b0}}, tick_i};
    end else if (tick_i && cnt_q < sat_i) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/vpw_classify.sv
module vpw_classify
  import vpw_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             active_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic [CNT_W-1:0] thr_b_i,
  input  logic [CNT_W-1:0] thr_c_i,
  input  logic [CNT_W-1:0] thr_d_i,
  input  logic [CNT_W-1:0] thr_e_i,
  input  logic [CNT_W-1:0] thr_f_i,
  input  logic [CNT_W-1:0] thr_g_i,
  output vpw_sym_e         sym_o
);
  always_comb begin
    if (active_i) begin
      if      (len_i < thr_b_i) sym_o = SYM_INVALID;
      else if (len_i < thr_c_i) sym_o = SYM_ONE;
      else if (len_i < thr_d_i) sym_o = SYM_ZERO;
      else                      sym_o = SYM_SOF;
    end else begin
      if      (len_i < thr_b_i) sym_o = SYM_INVALID;
      else if (len_i < thr_c_i) sym_o = SYM_ZERO;
      else if (len_i < thr_d_i) sym_o = SYM_ONE;
      else if (len_i < thr_e_i) sym_o = SYM_EOD;
      else if (len_i < thr_f_i) sym_o = SYM_EOF;
      else if (len_i < thr_g_i) sym_o = SYM_EOF_IFS;
      else                      sym_o = SYM_IDLE;
    end
  end
endmodule

// File: rtl/vpw_sym_decoder.sv
module vpw_sym_decoder
  import vpw_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             bus_i,
  input  logic [CNT_W-1:0] thr_b_i,
  input  logic [CNT_W-1:0] thr_c_i,
  input  logic [CNT_W-1:0] thr_d_i,
  input  logic [CNT_W-1:0] thr_e_i,
  input  logic [CNT_W-1:0] thr_f_i,
  input  logic [CNT_W-1:0] thr_g_i,
  input  logic             tx_pending_i,
  output logic             sym_valid_o,
  output logic [2:0]       sym_o,
  output logic             sym_active_o,
  output logic             tx_start_o,
  output logic             tx_grant_o
);
  logic             level, rise, fall, edge_hit;
  logic [CNT_W-1:0] cnt, sat;
  vpw_sym_e         cls;
  logic             idle_q, idle_hit;
  logic             valid_q, act_q, start_q;
  vpw_sym_e         sym_q;

  vpw_bus_filter #(
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_LEN   (FILT_LEN)
  ) u_filter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bus_i  (bus_i),
    .level_o(level),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign edge_hit = rise | fall;
  assign sat      = thr_g_i + CNT_W'(1);

  vpw_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .clear_i(edge_hit),
    .sat_i  (sat),
    .cnt_o  (cnt)
  );

  // fall ends an active phase, rise ends a passive one
  vpw_classify #(.CNT_W(CNT_W)) u_classify (
    .active_i(fall),
    .len_i   (cnt),
    .thr_b_i (thr_b_i),
    .thr_c_i (thr_c_i),
    .thr_d_i (thr_d_i),
    .thr_e_i (thr_e_i),
    .thr_f_i (thr_f_i),
    .thr_g_i (thr_g_i),
    .sym_o   (cls)
  );

  assign idle_hit = !level && !idle_q && (cnt >= thr_g_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q  <= 1'b0;
      valid_q <= 1'b0;
      act_q   <= 1'b0;
      start_q <= 1'b0;
      sym_q   <= SYM_INVALID;
    end else begin
      valid_q <= 1'b0;
      start_q <= 1'b0;
      if (edge_hit) begin
        idle_q <= 1'b0;
        // idle already reported by the timer: stay silent
        if (!(rise && cls == SYM_IDLE && idle_q)) begin
          valid_q <= 1'b1;
          sym_q   <= cls;
          act_q   <= fall;
        end
        start_q <= rise && tx_pending_i && (cnt >= thr_e_i);
      end else if (idle_hit) begin
        idle_q  <= 1'b1;
        valid_q <= 1'b1;
        sym_q   <= SYM_IDLE;
        act_q   <= 1'b0;
      end
    end
  end

  assign sym_valid_o  = valid_q;
  assign sym_o        = sym_q;
  assign sym_active_o = act_q;
  assign tx_start_o   = start_q;
  assign tx_grant_o   = tx_pending_i & idle_q & ~level;
endmodule

// File: rtl/vpw_sym_decoder_chk.sv
module vpw_sym_decoder_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tx_pending_i,
  input logic       sym_valid_o,
  input logic [2:0] sym_o,
  input logic       sym_active_o,
  input logic       tx_start_o,
  input logic       tx_grant_o
);
  AST_START_NEEDS_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |-> $past(tx_pending_i)); // R7

  AST_START_AFTER_EOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |-> (!sym_valid_o || (!sym_active_o && sym_o >= 3'd4 && sym_o <= 3'd6))); // R7

  AST_GRANT_NEEDS_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_grant_o |-> tx_pending_i); // R6

  AST_GRANT_OFF_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |-> !tx_grant_o); // R6

  AST_PASSIVE_NO_SOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_valid_o && !sym_active_o) |-> (sym_o != 3'd7)); // R2

  AST_ACTIVE_KINDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_valid_o && sym_active_o) |-> (sym_o <= 3'd2 || sym_o == 3'd7)); // R3

  AST_SYM_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_valid_o |=> !sym_valid_o); // R4
endmodule

bind vpw_sym_decoder vpw_sym_decoder_chk u_chk (.*);

// File: tb/tb_vpw_sym_decoder.sv
module tb_vpw_sym_decoder;
  localparam int CNT_W = 10;
  localparam int TB = 34, TC = 96, TD = 163, TE = 239, TF = 280, TG = 300;

  typedef struct {
    logic       act;
    logic [2:0] sym;
    string      tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b1;
  logic bus_i = 1'b0;
  logic tx_pending_i = 1'b0;
  logic sym_valid_o, sym_active_o, tx_start_o, tx_grant_o;
  logic [2:0] sym_o;
  bit half_rate = 1'b0;

  item_t exp_q[$];
  int total = 0;
  int bad = 0;
  int starts = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vpw_sym_decoder #(.CNT_W(CNT_W)) dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .bus_i       (bus_i),
    .thr_b_i     (CNT_W'(TB)),
    .thr_c_i     (CNT_W'(TC)),
    .thr_d_i     (CNT_W'(TD)),
    .thr_e_i     (CNT_W'(TE)),
    .thr_f_i     (CNT_W'(TF)),
    .thr_g_i     (CNT_W'(TG)),
    .tx_pending_i(tx_pending_i),
    .sym_valid_o (sym_valid_o),
    .sym_o       (sym_o),
    .sym_active_o(sym_active_o),
    .tx_start_o  (tx_start_o),
    .tx_grant_o  (tx_grant_o)
  );

  // R8: tick every cycle, or every second cycle
  always @(negedge clk) tick_i <= half_rate ? ~tick_i : 1'b1;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // R2 / R3 expected codes, computed from the threshold ladder
  function automatic logic [2:0] exp_cls(bit act, int n);
    if (act) begin
      if (n < TB) return 3'd0;
      if (n < TC) return 3'd2;
      if (n < TD) return 3'd1;
      return 3'd7;
    end
    if (n < TB) return 3'd0;
    if (n < TC) return 3'd1;
    if (n < TD) return 3'd2;
    if (n < TE) return 3'd3;
    if (n < TF) return 3'd4;
    if (n < TG) return 3'd5;
    return 3'd6;
  endfunction

  task automatic expect_sym(input bit act, input int n, input string tag);
    item_t it;
    it.act = act;
    it.sym = exp_cls(act, n);
    it.tag = tag;
    exp_q.push_back(it);
  endtask

  // driver: hold the bus level for n cycles, optionally scoring the phase
  task automatic phase(input bit lvl, input int n, input bit push, input string tag);
    if (push) expect_sym(lvl, n, tag);
    bus_i = lvl;
    repeat (n) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      if (tx_start_o) starts++;
      if (sym_valid_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R5", "unexpected symbol", int'(sym_o), -1);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          check(sym_o == it.sym, it.tag, "symbol code", int'(sym_o), int'(it.sym));
          check(sym_active_o == it.act, it.tag, "phase flag", int'(sym_active_o), int'(it.act));
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "all", "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    check(sym_valid_o == 1'b0 && tx_start_o == 1'b0 && tx_grant_o == 1'b0,
          "R1", "outputs in reset", int'({sym_valid_o, tx_start_o, tx_grant_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(sym_valid_o == 1'b0 && tx_start_o == 1'b0 && tx_grant_o == 1'b0,
          "R1", "outputs after release", int'({sym_valid_o, tx_start_o, tx_grant_o}), 0);

    // R5: idle reported once while the bus rests passive
    expect_sym(1'b0, TG, "R5");
    phase(1'b0, 330, 1'b0, "");
    tx_pending_i = 1'b1;
    #1;
    check(tx_grant_o == 1'b1, "R6", "grant after idle", int'(tx_grant_o), 1);
    tx_pending_i = 1'b0;
    #1;
    check(tx_grant_o == 1'b0, "R6", "grant without pending", int'(tx_grant_o), 0);
    phase(1'b0, 400, 1'b0, "");
    check(exp_q.size() == 0, "R5", "single idle report", exp_q.size(), 0);

    // threshold edges, active and passive
    phase(1'b1, 200, 1'b1, "R3");
    phase(1'b0, TB - 1, 1'b1, "R2");
    phase(1'b1, TB, 1'b1, "R3");
    phase(1'b0, TB, 1'b1, "R2");
    phase(1'b1, TC - 1, 1'b1, "R3");
    phase(1'b0, TC - 1, 1'b1, "R2");
    phase(1'b1, TC, 1'b1, "R3");
    phase(1'b0, TC, 1'b1, "R2");
    phase(1'b1, TD - 1, 1'b1, "R3");
    phase(1'b0, TD - 1, 1'b1, "R2");
    phase(1'b1, TD, 1'b1, "R3");
    phase(1'b0, TD, 1'b1, "R2");
    phase(1'b1, TB - 1, 1'b1, "R3");
    phase(1'b0, TE - 1, 1'b1, "R2");
    phase(1'b1, 64, 1'b1, "R3");
    phase(1'b0, TE, 1'b1, "R2");
    phase(1'b1, 64, 1'b1, "R3");
    phase(1'b0, TF - 1, 1'b1, "R2");
    phase(1'b1, 64, 1'b1, "R3");
    phase(1'b0, TF, 1'b1, "R2");
    phase(1'b1, 64, 1'b1, "R3");
    phase(1'b0, TG - 1, 1'b1, "R2");
    phase(1'b1, 64, 1'b1, "R3");
    phase(1'b0, TG, 1'b1, "R5");
    phase(1'b1, 64, 1'b1, "R3");
    check(starts == 0, "R7", "no start without pending", starts, 0);

    // R7: no start after end-of-data, start after end-of-frame
    tx_pending_i = 1'b1;
    phase(1'b0, TD, 1'b1, "R2");
    phase(1'b1, 64, 1'b1, "R3");
    check(starts == 0, "R7", "no start after end-of-data", starts, 0);
    expect_sym(1'b0, 250, "R2");
    phase(1'b0, 125, 1'b0, "");
    check(tx_grant_o == 1'b0, "R6", "no grant before separation", int'(tx_grant_o), 0);
    phase(1'b0, 125, 1'b0, "");
    phase(1'b1, 64, 1'b1, "R3");
    check(starts == 1, "R7", "start on edge after end-of-frame", starts, 1);
    tx_pending_i = 1'b0;

    // R4: two-cycle glitches inside a passive and an active phase
    expect_sym(1'b0, 102, "R4");
    phase(1'b0, 50, 1'b0, "");
    phase(1'b1, 2, 1'b0, "");
    phase(1'b0, 50, 1'b0, "");
    expect_sym(1'b1, 120, "R4");
    phase(1'b1, 60, 1'b0, "");
    phase(1'b0, 2, 1'b0, "");
    phase(1'b1, 58, 1'b0, "");

    // R8: half-rate tick halves the measured lengths
    half_rate = 1'b1;
    expect_sym(1'b0, 120, "R8");
    phase(1'b0, 240, 1'b0, "");
    expect_sym(1'b1, 64, "R8");
    phase(1'b1, 128, 1'b0, "");
    expect_sym(1'b0, 25, "R8");
    phase(1'b0, 50, 1'b0, "");
    half_rate = 1'b0;
    phase(1'b1, 64, 1'b1, "R3");

    // R6 / R7: own-initiative grant after idle, then start on the edge
    tx_pending_i = 1'b1;
    phase(1'b0, 330, 1'b1, "R5");
    check(tx_grant_o == 1'b1, "R6", "grant after idle with pending", int'(tx_grant_o), 1);
    phase(1'b0, 70, 1'b0, "");
    phase(1'b1, 64, 1'b1, "R3");
    check(tx_grant_o == 1'b0, "R6", "grant low while active", int'(tx_grant_o), 0);
    check(starts == 2, "R7", "start after idle", starts, 2);
    tx_pending_i = 1'b0;
    phase(1'b0, 20, 1'b0, "");

    check(exp_q.size() == 0, "R2", "all expected symbols seen", exp_q.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule